// File: doc/BRIEF.md
# Word-to-Flit Network Adapter

This block connects a 32-bit processor data port to a 16-bit network-on-chip link. A send request names a destination and a length in words. The transmit machine then puts a header flit carrying the destination on the link, followed by a size flit that holds the number of payload flits. It then pulls the payload one word at a time from a DMA word stream. Each word goes out as two flits, the upper half first.

On the receive side a second, independent machine takes the header and size flits of an incoming packet. It then rebuilds words from pairs of data flits and pushes them into a small word buffer that the processor drains through a valid/read handshake. Accepting a header raises a one-cycle interrupt pulse, and the header flit stays visible on a port. When the buffer is full, the receiver holds off data flits by lowering its link ready signal.

Top module: `nif_flit_bridge`

## Requirements
- R1: After reset, tx_busy, link_out_valid, dma_word_ready, rx_irq and cpu_rd_valid are low and link_in_ready is high.
- R2: A packet leaves the link as the header flit (tx_dest), then a size flit equal to twice tx_len, then for each word its bits 31:16 followed by its bits 15:0. The total is 2 + 2*tx_len flits.
- R3: Exactly tx_len words are taken from the DMA stream for a packet, one per cycle in which dma_word_valid and dma_word_ready are both high, and dma_word_ready stays low while tx_busy is low.
- R4: A flit moves on a link only in a cycle with both valid and ready high. A stalled output flit keeps its value and its valid until it is taken.
- R5: tx_start is accepted only while tx_busy is low, and tx_busy is high in the next cycle. A tx_start while busy has no effect on the flit stream.
- R6: A packet with tx_len of zero carries only header and size flits. The receiver stores no word for it and returns to waiting for a header.
- R7: The receiver joins each pair of data flits into one word, with the first flit as the upper half. The processor reads the words in arrival order, across packets.
- R8: The word buffer holds 16 words. In the data phase link_in_ready is low exactly when the buffer is full. While waiting for a header or size flit, link_in_ready is high.
- R9: rx_irq is high for exactly the one cycle after a header flit is accepted, and rx_header then shows that flit.
- R10: cpu_rd_valid is high exactly when the buffer holds a word. cpu_rd removes the oldest word, and a cpu_rd on an empty buffer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Begin a packet (taken when idle) |
| tx_dest | input | 16 | Destination, sent as the header flit |
| tx_len | input | LEN_W (8) | Payload length in words |
| tx_busy | output | 1 | Transmit machine is not idle |
| dma_word_valid | input | 1 | DMA offers a word |
| dma_word | input | 32 | Word offered by the DMA |
| dma_word_ready | output | 1 | Transmit side takes the offered word |
| link_out_valid | output | 1 | Outgoing flit valid |
| link_out_flit | output | 16 | Outgoing flit |
| link_out_ready | input | 1 | Link accepts the outgoing flit |
| link_in_valid | input | 1 | Incoming flit valid |
| link_in_flit | input | 16 | Incoming flit |
| link_in_ready | output | 1 | Adapter accepts the incoming flit |
| rx_irq | output | 1 | One-cycle packet-arrival interrupt |
| rx_header | output | 16 | Header flit of the latest packet |
| cpu_rd_valid | output | 1 | Buffer holds at least one word |
| cpu_rd_data | output | 32 | Oldest buffered word |
| cpu_rd | input | 1 | Processor consumes the oldest word |

## Verification
The bench builds the adapter with 16-bit flits and a 16-word buffer, but with LEN_W set to 5. This makes every packet length from 0 to 31 words reachable in a short run. The outgoing link is looped straight back into the receiver, and all 32 lengths are swept three times. In the first sweep the processor reads every cycle, including on an empty buffer. In the second it reads only every fifth cycle, so packets longer than the buffer force receive back-pressure and the transmitter stalls mid-word, while stray start pulses arrive during each packet. In the third the DMA offers a word only every other cycle.

// File: rtl/nif_pkg.sv
package nif_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HEADER,
        TX_SIZE,
        TX_WORD_HI,
        TX_WORD_LO,
        TX_DONE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_WAIT_HDR,
        RX_WAIT_SIZE,
        RX_HI,
        RX_LO
    } rx_state_e;

endpackage

// File: rtl/nif_tx_fsm.sv
module nif_tx_fsm
    import nif_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FLIT_W-1:0]   dest,
    input  logic [LEN_W-1:0]    len,
    output logic                busy,
    input  logic                word_valid,
    input  logic [2*FLIT_W-1:0] word,
    output logic                word_ready,
    output logic                flit_valid,
    output logic [FLIT_W-1:0]   flit,
    input  logic                flit_ready
);
    localparam int WORD_W = 2 * FLIT_W;
    localparam int PAD_W  = FLIT_W - LEN_W - 1;

    typedef struct packed {
        tx_state_e          state;
        logic [FLIT_W-1:0]  dest;
        logic [LEN_W-1:0]   total;
        logic [LEN_W-1:0]   left;
        logic [WORD_W-1:0]  word;
        logic               have;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [FLIT_W-1:0] size_flit;

    assign size_flit = {{PAD_W{1'b0}}, q.total, 1'b0};
    assign busy      = (q.state != TX_IDLE);

    always_comb begin
        d          = q;
        word_ready = 1'b0;
        flit_valid = 1'b0;
        flit       = '0;
        case (q.state)
            TX_IDLE: begin
                if (start) begin
                    d.dest  = dest;
                    d.total = len;
                    d.left  = len;
                    d.have  = 1'b0;
                    d.state = TX_HEADER;
                end
            end
            TX_HEADER: begin
                flit_valid = 1'b1;
                flit       = q.dest;
                if (flit_ready) d.state = TX_SIZE;
            end
            TX_SIZE: begin
                flit_valid = 1'b1;
                flit       = size_flit;
                word_ready = !q.have && (q.left != '0);
                if (flit_ready) d.state = (q.left == '0) ? TX_DONE : TX_WORD_HI;
            end
            TX_WORD_HI: begin
                word_ready = !q.have;
                flit_valid = q.have;
                flit       = q.word[WORD_W-1:FLIT_W];
                if (q.have && flit_ready) d.state = TX_WORD_LO;
            end
            TX_WORD_LO: begin
                flit_valid = 1'b1;
                flit       = q.word[FLIT_W-1:0];
                if (flit_ready) begin
                    d.have  = 1'b0;
                    d.left  = q.left - 1'b1;
                    d.state = (q.left == LEN_W'(1)) ? TX_DONE : TX_WORD_HI;
                end
            end
            TX_DONE: begin
                d.state = TX_IDLE;
            end
            default: d.state = TX_IDLE;
        endcase
        if (word_ready && word_valid) begin
            d.word = word;
            d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nif_rx_fsm.sv
module nif_rx_fsm
    import nif_pkg::*;
#(
    parameter int FLIT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flit_valid,
    input  logic [FLIT_W-1:0]   flit,
    output logic                flit_ready,
    input  logic                buf_full,
    output logic                push,
    output logic [2*FLIT_W-1:0] push_word,
    output logic                irq,
    output logic [FLIT_W-1:0]   hdr
);
    localparam int CNT_W = FLIT_W - 1;

    typedef struct packed {
        rx_state_e          state;
        logic [FLIT_W-1:0]  hi;
        logic [CNT_W-1:0]   left;
        logic               irq;
        logic [FLIT_W-1:0]  hdr;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [CNT_W-1:0] size_words;

    assign size_words = flit[FLIT_W-1:1];
    assign irq        = q.irq;
    assign hdr        = q.hdr;
    assign push_word  = {q.hi, flit};

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        push       = 1'b0;
        flit_ready = 1'b1;
        case (q.state)
            RX_WAIT_HDR: begin
                if (flit_valid) begin
                    d.hdr   = flit;
                    d.irq   = 1'b1;
                    d.state = RX_WAIT_SIZE;
                end
            end
            RX_WAIT_SIZE: begin
                if (flit_valid) begin
                    d.left  = size_words;
                    d.state = (size_words == '0) ? RX_WAIT_HDR : RX_HI;
                end
            end
            RX_HI: begin
                flit_ready = !buf_full;
                if (flit_valid && !buf_full) begin
                    d.hi    = flit;
                    d.state = RX_LO;
                end
            end
            RX_LO: begin
                flit_ready = !buf_full;
                if (flit_valid && !buf_full) begin
                    push    = 1'b1;
                    d.left  = q.left - 1'b1;
                    d.state = (q.left == CNT_W'(1)) ? RX_WAIT_HDR : RX_HI;
                end
            end
            default: d.state = RX_WAIT_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nif_word_fifo.sv
module nif_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop,
    output logic [WORD_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_valid = (q.cnt != '0);
    assign full      = (q.cnt == CNT_W'(DEPTH));
    assign count     = q.cnt;
    assign pop_data  = q.mem[q.rd];
    assign do_push   = push && !full;
    assign do_pop    = pop && pop_valid;

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wr] = push_data;
            d.wr        = bump(q.wr);
        end
        if (do_pop) begin
            d.rd = bump(q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.wr  <= '0;
            q.rd  <= '0;
            q.cnt <= '0;
            q.mem <= q.mem;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nif_flit_bridge.sv
module nif_flit_bridge #(
    parameter int FLIT_W    = 16,
    parameter int BUF_DEPTH = 16,
    parameter int LEN_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_start,
    input  logic [FLIT_W-1:0]   tx_dest,
    input  logic [LEN_W-1:0]    tx_len,
    output logic                tx_busy,
    input  logic                dma_word_valid,
    input  logic [2*FLIT_W-1:0] dma_word,
    output logic                dma_word_ready,
    output logic                link_out_valid,
    output logic [FLIT_W-1:0]   link_out_flit,
    input  logic                link_out_ready,
    input  logic                link_in_valid,
    input  logic [FLIT_W-1:0]   link_in_flit,
    output logic                link_in_ready,
    output logic                rx_irq,
    output logic [FLIT_W-1:0]   rx_header,
    output logic                cpu_rd_valid,
    output logic [2*FLIT_W-1:0] cpu_rd_data,
    input  logic                cpu_rd
);
    localparam int WORD_W = 2 * FLIT_W;
    localparam int CNT_W  = $clog2(BUF_DEPTH + 1);

    logic              buf_full;
    logic              rx_push;
    logic [WORD_W-1:0] rx_word;
    logic [CNT_W-1:0]  occupancy;

    nif_tx_fsm #(.FLIT_W(FLIT_W), .LEN_W(LEN_W)) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .dest       (tx_dest),
        .len        (tx_len),
        .busy       (tx_busy),
        .word_valid (dma_word_valid),
        .word       (dma_word),
        .word_ready (dma_word_ready),
        .flit_valid (link_out_valid),
        .flit       (link_out_flit),
        .flit_ready (link_out_ready)
    );

    nif_rx_fsm #(.FLIT_W(FLIT_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flit_valid (link_in_valid),
        .flit       (link_in_flit),
        .flit_ready (link_in_ready),
        .buf_full   (buf_full),
        .push       (rx_push),
        .push_word  (rx_word),
        .irq        (rx_irq),
        .hdr        (rx_header)
    );

    nif_word_fifo #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_word),
        .pop       (cpu_rd),
        .pop_data  (cpu_rd_data),
        .pop_valid (cpu_rd_valid),
        .full      (buf_full),
        .count     (occupancy)
    );

endmodule

// File: rtl/nif_bridge_checker.sv
module nif_bridge_checker #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_start,
    input logic              tx_busy,
    input logic              dma_word_ready,
    input logic              link_out_valid,
    input logic [FLIT_W-1:0] link_out_flit,
    input logic              link_out_ready,
    input logic              rx_irq,
    input logic              cpu_rd,
    input logic [CNT_W-1:0]  occupancy
);

    AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        link_out_valid && !link_out_ready |=> link_out_valid && $stable(link_out_flit)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH)); // R8

    AST_FULL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CNT_W'(DEPTH)) && !cpu_rd |=> occupancy == CNT_W'(DEPTH)); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq); // R9

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start && !tx_busy |=> tx_busy); // R5

    AST_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !dma_word_ready); // R3

endmodule

bind nif_flit_bridge nif_bridge_checker #(
    .FLIT_W (FLIT_W),
    .DEPTH  (BUF_DEPTH),
    .CNT_W  (CNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tx_start       (tx_start),
    .tx_busy        (tx_busy),
    .dma_word_ready (dma_word_ready),
    .link_out_valid (link_out_valid),
    .link_out_flit  (link_out_flit),
    .link_out_ready (link_out_ready),
    .rx_irq         (rx_irq),
    .cpu_rd         (cpu_rd),
    .occupancy      (occupancy)
);

// File: tb/nif_flit_bridge_tb_top.sv
module nif_flit_bridge_tb_top;
    localparam int FLIT_W = 16;
    localparam int DEPTH  = 16;
    localparam int LEN_W  = 5;
    localparam int LIMIT  = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_start = 1'b0;
    logic [15:0]       tx_dest = '0;
    logic [LEN_W-1:0]  tx_len = '0;
    logic              tx_busy;
    logic              dma_word_valid = 1'b0;
    logic [31:0]       dma_word = '0;
    logic              dma_word_ready;
    logic              link_out_valid;
    logic [15:0]       link_out_flit;
    logic              link_in_ready;
    logic              rx_irq;
    logic [15:0]       rx_header;
    logic              cpu_rd_valid;
    logic [31:0]       cpu_rd_data;
    logic              cpu_rd = 1'b0;

    always #5 clk = ~clk;

    nif_flit_bridge #(.FLIT_W(FLIT_W), .BUF_DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_start       (tx_start),
        .tx_dest        (tx_dest),
        .tx_len         (tx_len),
        .tx_busy        (tx_busy),
        .dma_word_valid (dma_word_valid),
        .dma_word       (dma_word),
        .dma_word_ready (dma_word_ready),
        .link_out_valid (link_out_valid),
        .link_out_flit  (link_out_flit),
        .link_out_ready (link_in_ready),
        .link_in_valid  (link_out_valid),
        .link_in_flit   (link_out_flit),
        .link_in_ready  (link_in_ready),
        .rx_irq         (rx_irq),
        .rx_header      (rx_header),
        .cpu_rd_valid   (cpu_rd_valid),
        .cpu_rd_data    (cpu_rd_data),
        .cpu_rd         (cpu_rd)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int round = 0;

    logic             rst_s = 1'b0;
    logic             start_s = 1'b0;
    logic             junk_s = 1'b0;
    logic [15:0]      dest_s = '0;
    logic [LEN_W-1:0] len_s = '0;

    bit          pkt_active = 0;
    bit          just_started = 0;
    int          cur_id = 0;
    int          cur_len = 0;
    logic [15:0] cur_dest = '0;
    int          pos = 0;
    int          dma_idx = 0;
    int          pkt_push = 0;
    int          occ = 0;
    bit          prev_hdr = 0;
    logic [15:0] prev_dest = '0;
    int          irq_cnt = 0;
    int          irq_exp = 0;
    int          pkt_seq = 0;

    logic [31:0] exp_q [0:2047];
    int          qw = 0;
    int          qr = 0;

    function automatic logic [31:0] wgen(input int pk, input int i);
        return 32'(pk) * 32'h0100_0193 + 32'(i) * 32'h9E37_79B1 + 32'h5A5A_0001;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic observe();
        bit          fhs;
        bit          data_phase;
        bit          pushed;
        bit          popped;
        logic [31:0] w;
        logic [15:0] ef;
        int          pos_before;
        fhs        = link_out_valid && link_in_ready;
        data_phase = pkt_active && pos >= 2 && pos < 2 + 2 * cur_len;
        pushed     = 0;
        pos_before = pos;

        if (just_started) begin
            chk(tx_busy == 1'b1, "R5 busy after start", 32'(tx_busy), 32'd1);
            just_started = 0;
        end
        // R8: ready follows fullness only in the data phase
        chk(link_in_ready == (data_phase ? (occ < DEPTH) : 1'b1), "R8 link_in_ready",
            32'(link_in_ready), 32'(data_phase ? (occ < DEPTH) : 1));
        chk(cpu_rd_valid == (occ != 0), "R10 cpu_rd_valid", 32'(cpu_rd_valid), 32'(occ != 0));
        chk(rx_irq == prev_hdr, "R9 irq timing", 32'(rx_irq), 32'(prev_hdr));
        if (rx_irq) begin
            irq_cnt++;
            chk(rx_header == prev_dest, "R9 rx_header", 32'(rx_header), 32'(prev_dest));
        end
        if (!tx_busy) chk(!dma_word_ready, "R3 word ready while idle", 32'(dma_word_ready), 32'd0);

        if (fhs) begin
            if (!pkt_active) begin
                chk(1'b0, "R5 flit outside packet", 32'(link_out_flit), 32'd0);
            end else begin
                if (pos == 0) ef = cur_dest;
                else if (pos == 1) ef = 16'(cur_len * 2);
                else begin
                    w  = wgen(cur_id, (pos - 2) / 2);
                    ef = ((pos - 2) % 2 == 0) ? w[31:16] : w[15:0];
                    if ((pos - 2) % 2 == 1) pushed = 1;
                end
                chk(link_out_flit == ef, (pos < 2) ? "R2 header/size flit" : "R2 data flit",
                    32'(link_out_flit), 32'(ef));
                pos++;
            end
        end

        popped = cpu_rd && cpu_rd_valid;
        if (popped) begin
            chk(cpu_rd_data == exp_q[qr], "R7 word order", cpu_rd_data, exp_q[qr]);
            qr++;
        end
        if (dma_word_valid && dma_word_ready) dma_idx++;

        prev_hdr = fhs && pkt_active && pos_before == 0;
        if (prev_hdr) prev_dest = cur_dest;

        occ      = occ + int'(pushed) - int'(popped);
        pkt_push = pkt_push + int'(pushed);

        if (pkt_active && !tx_busy) begin
            chk(pos == 2 + 2 * cur_len, "R2 flit count", 32'(pos), 32'(2 + 2 * cur_len));
            chk(dma_idx == cur_len, "R3 DMA words", 32'(dma_idx), 32'(cur_len));
            chk(pkt_push == cur_len, (cur_len == 0) ? "R6 empty packet" : "R7 words stored",
                32'(pkt_push), 32'(cur_len));
            pkt_active = 0;
        end
        if (start_s && !tx_busy && !pkt_active) begin
            pkt_active   = 1;
            just_started = 1;
            cur_id       = pkt_seq;
            pkt_seq++;
            cur_len      = int'(len_s);
            cur_dest     = dest_s;
            pos          = 0;
            dma_idx      = 0;
            pkt_push     = 0;
            irq_exp++;
            for (int i = 0; i < cur_len; i++) begin
                exp_q[qw] = wgen(cur_id, i);
                qw++;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        rst_n          = rst_s;
        tx_start       = start_s | (junk_s & tx_busy);
        tx_dest        = start_s ? dest_s : 16'hDEAD;
        tx_len         = start_s ? len_s : LEN_W'(7);
        dma_word_valid = (round != 2) || cyc[0];
        dma_word       = wgen(cur_id, dma_idx);
        cpu_rd         = (round == 1) ? (cyc % 5 == 0) : 1'b1;
        #4;
        if (rst_n) observe();
        cyc++;
    endtask

    initial begin
        #(150000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_s = 1'b0;
        for (int i = 0; i < 3; i++) step();
        rst_s = 1'b1;
        step();
        // R1: reset state seen before the first active edge
        chk(!tx_busy, "R1 tx_busy", 32'(tx_busy), 32'd0);
        chk(!link_out_valid, "R1 link_out_valid", 32'(link_out_valid), 32'd0);
        chk(!dma_word_ready, "R1 dma_word_ready", 32'(dma_word_ready), 32'd0);
        chk(!rx_irq, "R1 rx_irq", 32'(rx_irq), 32'd0);
        chk(!cpu_rd_valid, "R1 cpu_rd_valid", 32'(cpu_rd_valid), 32'd0);
        chk(link_in_ready, "R1 link_in_ready", 32'(link_in_ready), 32'd1);

        for (int r = 0; r < 3; r++) begin
            round = r;
            for (int p = 0; p < 32; p++) begin
                len_s   = LEN_W'((r == 2) ? 31 - p : p);
                dest_s  = 16'h4000 + 16'(r * 256 + p);
                start_s = 1'b1;
                step();
                start_s = 1'b0;
                junk_s  = (r == 1);
                while (pkt_active && cyc < LIMIT) step();
                junk_s  = 1'b0;
            end
        end
        round = 0;
        while (qr != qw && cyc < LIMIT) step();
        for (int i = 0; i < 4; i++) step();
        chk(qr == qw, "R7 all words read", 32'(qr), 32'(qw));
        chk(irq_cnt == irq_exp, "R9 irq count", 32'(irq_cnt), 32'(irq_exp));
        chk(occ == 0 && !cpu_rd_valid, "R10 buffer drained", 32'(cpu_rd_valid), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule